// File: doc/BRIEF.md
# Two-Level Page Translation Walker

The walker turns a 32-bit linear address into a physical address. It accepts one request at a time on a valid/ready port. Each request carries the linear address and the access kind: write or read, and user or supervisor. The walker samples three control inputs when it accepts a request: a paging enable, a large-page enable and the frame number of the page directory. If paging is enabled, it fetches 32-bit entries from a two-level structure in memory. It uses a word-read port with a request handshake and a one-cycle response strobe. The result goes back on a valid/ready port. A result is either a physical address or a page fault with a three-bit code.

The linear page number splits into a 10-bit directory index (bits 31:22) and a 10-bit table index (bits 21:12). The low 12 bits are the byte offset. Each directory entry has a size flag. When the large-page enable is set, that flag lets a directory entry map a 4 MB page on its own, so 4 KB and 4 MB pages can sit in the same directory. When paging is off, the walker returns the address unchanged and reads nothing.

Top module: `xlate_walker`

## Requirements
- R1: When `pg_en` is 0 at acceptance, the result is the linear address unchanged. There is no fault, the code is 0 and no memory read is issued.
- R2: The first read of a walk goes to the word address {`dir_frame`, lin[31:22], 2'b00}. Every memory read address has bits 1:0 equal to 0.
- R3: Entry bits are: 0 present, 1 writable, 2 user-allowed, 7 size (directory only), 31:12 frame. A directory entry that points to a table causes a second read at {entry[31:12], lin[21:12], 2'b00}. The result is then {table entry[31:12], lin[11:0]}.
- R4: A present directory entry with bit 7 set, read while `pse_en` was 1 at acceptance, maps a 4 MB page. The walk makes exactly one read, and the result is {entry[31:22], lin[21:0]}.
- R5: When `pse_en` was 0 at acceptance, directory bit 7 is ignored and the entry is used as a table pointer (two reads).
- R6: An entry with bit 0 clear, at either level, gives a fault with code bit 0 = 0. Fault code layout: bit 0 = 1 for a protection fault and 0 for not-present; bit 1 = access was a write; bit 2 = access was from user. On a fault the physical address is 0. Without a fault the code is 0. A not-present table entry reports not-present even if the directory entry lacks rights.
- R7: A write faults with code bit 0 = 1 if the writable bit is clear in the directory entry or in the table entry, or in the single directory entry of a 4 MB page.
- R8: A user access faults with code bit 0 = 1 if the user bit is clear at any level used. Supervisor reads need neither bit.
- R9: When a write and a user access both lack rights, one fault is reported with code 3'b111.
- R10: `req_ready` is 1 only while idle. It stays 0 from acceptance until the result is taken with `rsp_ready`. A result held by `rsp_ready` = 0 keeps `rsp_valid`, `rsp_phys`, `rsp_fault` and `rsp_fault_code` unchanged.
- R11: A memory request held by `mem_req_ready` = 0 keeps `mem_req_valid` and `mem_req_addr` unchanged.
- R12: `pg_en`, `pse_en` and `dir_frame` are sampled only at acceptance. Changes to them during a walk do not affect that walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_lin | input | 32 | Linear address |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user level |
| pg_en | input | 1 | Paging enable |
| pse_en | input | 1 | Large-page enable |
| dir_frame | input | 20 | Frame number of the page directory |
| mem_req_valid | output | 1 | Memory word read requested |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the word to read |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 32 | Read data |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Result taken |
| rsp_phys | output | 32 | Physical address (0 on fault) |
| rsp_fault | output | 1 | Page fault |
| rsp_fault_code | output | 3 | Fault code |

## Verification
The write-rights check and the user-rights check run in the same cycle on the same entry. The bench makes them collide with a user write to a 4 MB page whose entry grants neither right, and expects exactly one fault with code 3'b111. A not-present table entry under a directory entry that lacks user rights also brings two fault causes into one walk. There the not-present code must win. A behavioural model computes each expected address, code and read sequence from the bench's own memory contents. The memory side stalls requests and varies the response latency, so the outcome does not depend on timing.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_DIR_REQ  = 3'd1,
        ST_DIR_WAIT = 3'd2,
        ST_TBL_REQ  = 3'd3,
        ST_TBL_WAIT = 3'd4,
        ST_DONE     = 3'd5
    } walk_state_e;

    // entry flag positions
    localparam int unsigned EB_PRESENT = 0;
    localparam int unsigned EB_WRITE   = 1;
    localparam int unsigned EB_USER    = 2;
    localparam int unsigned EB_SIZE    = 7;

    // fault code positions
    localparam int unsigned FC_PROT = 0;
    localparam int unsigned FC_WR   = 1;
    localparam int unsigned FC_USR  = 2;
    localparam int unsigned FC_W    = 3;
endpackage

// File: rtl/xlate_entry_dec.sv
module xlate_entry_dec
    import xlate_pkg::*;
#(
    parameter int unsigned ENT_W       = 32,
    parameter int unsigned OFF_W       = 12,
    parameter int unsigned BIG_FRAME_W = 10,
    localparam int unsigned FRAME_W    = ENT_W - OFF_W
) (
    input  logic [ENT_W-1:0]       entry,
    output logic                   present,
    output logic                   can_write,
    output logic                   can_user,
    output logic                   big,
    output logic [FRAME_W-1:0]     frame,
    output logic [BIG_FRAME_W-1:0] big_frame
);
    logic unused_flags;

    assign present   = entry[EB_PRESENT];
    assign can_write = entry[EB_WRITE];
    assign can_user  = entry[EB_USER];
    assign big       = entry[EB_SIZE];
    assign frame     = entry[ENT_W-1 -: FRAME_W];
    assign big_frame = entry[ENT_W-1 -: BIG_FRAME_W];

    assign unused_flags = ^{entry[OFF_W-1:EB_SIZE+1], entry[EB_SIZE-1:EB_USER+1]};
endmodule

// File: rtl/xlate_perm.sv
module xlate_perm
    import xlate_pkg::*;
(
    input  logic            acc_write,
    input  logic            acc_user,
    input  logic            present,
    input  logic            allow_write,
    input  logic            allow_user,
    output logic            fault,
    output logic [FC_W-1:0] code
);
    logic viol;

    always_comb begin
        viol  = (acc_write && !allow_write) || (acc_user && !allow_user);
        fault = !present || viol;
        code  = '0;
        if (fault) begin
            code[FC_PROT] = present;
            code[FC_WR]   = acc_write;
            code[FC_USR]  = acc_user;
        end
    end
endmodule

// File: rtl/xlate_walker.sv
module xlate_walker
    import xlate_pkg::*;
#(
    parameter int unsigned LIN_W     = 32,
    parameter int unsigned DIR_IDX_W = 10,
    parameter int unsigned TBL_IDX_W = 10,
    localparam int unsigned OFF_W     = LIN_W - DIR_IDX_W - TBL_IDX_W,
    localparam int unsigned FRAME_W   = LIN_W - OFF_W,
    localparam int unsigned BIG_OFF_W = OFF_W + TBL_IDX_W,
    localparam int unsigned WORD_SH   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [LIN_W-1:0]   req_lin,
    input  logic               req_write,
    input  logic               req_user,
    input  logic               pg_en,
    input  logic               pse_en,
    input  logic [FRAME_W-1:0] dir_frame,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [LIN_W-1:0]   mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic [LIN_W-1:0]   mem_rsp_data,
    output logic               rsp_valid,
    input  logic               rsp_ready,
    output logic [LIN_W-1:0]   rsp_phys,
    output logic               rsp_fault,
    output logic [FC_W-1:0]    rsp_fault_code
);
    typedef struct packed {
        walk_state_e        state;
        logic [LIN_W-1:0]   lin;
        logic               wr;
        logic               usr;
        logic               pg;
        logic               pse;
        logic [FRAME_W-1:0] dframe;
        logic [FRAME_W-1:0] tframe;
        logic               dir_w;
        logic               dir_u;
        logic [LIN_W-1:0]   phys;
        logic               fault;
        logic [FC_W-1:0]    code;
    } walk_s;

    walk_s q, d;

    logic                 e_present, e_write, e_user, e_big;
    logic [FRAME_W-1:0]   e_frame;
    logic [DIR_IDX_W-1:0] e_big_frame;
    logic                 dir_fault, tbl_fault;
    logic [FC_W-1:0]      dir_code, tbl_code;

    xlate_entry_dec #(
        .ENT_W(LIN_W), .OFF_W(OFF_W), .BIG_FRAME_W(DIR_IDX_W)
    ) u_dec (
        .entry(mem_rsp_data), .present(e_present), .can_write(e_write),
        .can_user(e_user), .big(e_big), .frame(e_frame), .big_frame(e_big_frame)
    );

    // rights of the directory entry alone (4 MB pages, not-present directory)
    xlate_perm u_dir_perm (
        .acc_write(q.wr), .acc_user(q.usr), .present(e_present),
        .allow_write(e_write), .allow_user(e_user),
        .fault(dir_fault), .code(dir_code)
    );

    // rights accumulated over both levels
    xlate_perm u_tbl_perm (
        .acc_write(q.wr), .acc_user(q.usr), .present(e_present),
        .allow_write(e_write && q.dir_w), .allow_user(e_user && q.dir_u),
        .fault(tbl_fault), .code(tbl_code)
    );

    always_comb begin
        d = q;
        unique case (q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    d.lin    = req_lin;
                    d.wr     = req_write;
                    d.usr    = req_user;
                    d.pg     = pg_en;
                    d.pse    = pse_en;
                    d.dframe = dir_frame;
                    if (!pg_en) begin
                        d.phys  = req_lin;
                        d.fault = 1'b0;
                        d.code  = '0;
                        d.state = ST_DONE;
                    end else begin
                        d.state = ST_DIR_REQ;
                    end
                end
            end
            ST_DIR_REQ: if (mem_req_ready) d.state = ST_DIR_WAIT;
            ST_DIR_WAIT: begin
                if (mem_rsp_valid) begin
                    if (!e_present || (e_big && q.pse)) begin
                        d.fault = dir_fault;
                        d.code  = dir_code;
                        d.phys  = dir_fault ? '0 : {e_big_frame, q.lin[BIG_OFF_W-1:0]};
                        d.state = ST_DONE;
                    end else begin
                        d.tframe = e_frame;
                        d.dir_w  = e_write;
                        d.dir_u  = e_user;
                        d.state  = ST_TBL_REQ;
                    end
                end
            end
            ST_TBL_REQ: if (mem_req_ready) d.state = ST_TBL_WAIT;
            ST_TBL_WAIT: begin
                if (mem_rsp_valid) begin
                    d.fault = tbl_fault;
                    d.code  = tbl_code;
                    d.phys  = tbl_fault ? '0 : {e_frame, q.lin[OFF_W-1:0]};
                    d.state = ST_DONE;
                end
            end
            ST_DONE: if (rsp_ready) d.state = ST_IDLE;
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req_ready      = (q.state == ST_IDLE);
    assign mem_req_valid  = (q.state == ST_DIR_REQ) || (q.state == ST_TBL_REQ);
    assign mem_req_addr   = (q.state == ST_TBL_REQ)
                          ? {q.tframe, q.lin[BIG_OFF_W-1:OFF_W], {WORD_SH{1'b0}}}
                          : {q.dframe, q.lin[LIN_W-1:BIG_OFF_W], {WORD_SH{1'b0}}};
    assign rsp_valid      = (q.state == ST_DONE);
    assign rsp_phys       = q.phys;
    assign rsp_fault      = q.fault;
    assign rsp_fault_code = q.code;
endmodule

module xlate_walker_chk #(
    parameter int unsigned LIN_W = 32,
    parameter int unsigned OFF_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             rsp_valid,
    input logic             rsp_ready,
    input logic [LIN_W-1:0] rsp_phys,
    input logic             rsp_fault,
    input logic [2:0]       rsp_fault_code,
    input logic             mem_req_valid,
    input logic             mem_req_ready,
    input logic [LIN_W-1:0] mem_req_addr,
    input logic             walk_pg,
    input logic [OFF_W-1:0] walk_off
);
    // R1
    nopage_noread_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> walk_pg);
    // R2
    word_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[1:0] == 2'b00));
    // R3
    offset_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (rsp_phys[OFF_W-1:0] == walk_off));
    // R6
    clean_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (rsp_fault_code == 3'b000));
    // R6
    fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_phys == '0));
    // R10
    single_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);
    // R10
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_phys)
                                       && $stable(rsp_fault) && $stable(rsp_fault_code)));
    // R11
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
endmodule

bind xlate_walker xlate_walker_chk #(.LIN_W(LIN_W), .OFF_W(OFF_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_phys(rsp_phys),
    .rsp_fault(rsp_fault), .rsp_fault_code(rsp_fault_code),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .walk_pg(q.pg), .walk_off(q.lin[OFF_W-1:0])
);

// File: tb/xlate_walker_tb.sv
module xlate_walker_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
    logic        req_ready;
    logic [31:0] req_lin = '0;
    logic        pg_en = 1'b0, pse_en = 1'b0;
    logic [19:0] dir_frame = '0;
    logic        mem_req_valid, mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        rsp_valid, rsp_ready = 1'b0, rsp_fault;
    logic [31:0] rsp_phys;
    logic [2:0]  rsp_fault_code;

    int n_chk = 0, n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xlate_walker u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_lin(req_lin), .req_write(req_write), .req_user(req_user),
        .pg_en(pg_en), .pse_en(pse_en), .dir_frame(dir_frame),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_phys(rsp_phys), .rsp_fault(rsp_fault), .rsp_fault_code(rsp_fault_code)
    );

    // ---------------- memory model ----------------
    logic [31:0] mem_a [logic [31:0]];
    logic [31:0] rd_q [$];
    int          cyc = 0, n_rd = 0, pend_cnt = 0;
    bit          pend = 1'b0;
    logic [31:0] pend_addr = '0;

    function automatic logic [31:0] memrd(input logic [31:0] a);
        return mem_a.exists(a) ? mem_a[a] : 32'h0;
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        mem_req_ready <= ((cyc % 4) != 1);
        mem_rsp_valid <= 1'b0;
        if (pend) begin
            if (pend_cnt == 0) begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_data  <= memrd(pend_addr);
                pend          <= 1'b0;
            end else begin
                pend_cnt <= pend_cnt - 1;
            end
        end
        if (mem_req_valid && mem_req_ready) begin
            pend      <= 1'b1;
            pend_addr <= mem_req_addr;
            pend_cnt  <= n_rd % 3;
            n_rd      <= n_rd + 1;
            rd_q.push_back(mem_req_addr);
        end
    end

    // ---------------- reference model ----------------
    task automatic ref_walk(input logic [31:0] lin, input logic wr, usr, pg, pse,
                            input logic [19:0] base,
                            output logic [31:0] phys, output logic flt,
                            output logic [2:0] code, output int nrd,
                            output logic [31:0] a0, a1);
        logic [31:0] pde, pte;
        logic okw, oku;
        phys = 0; flt = 0; code = 0; nrd = 0; a0 = 0; a1 = 0;
        if (!pg) begin
            phys = lin;
            return;
        end
        a0 = {base, lin[31:22], 2'b00};
        pde = memrd(a0);
        nrd = 1;
        if (!pde[0]) begin
            flt = 1; code = {usr, wr, 1'b0};
            return;
        end
        if (pde[7] && pse) begin
            okw = pde[1]; oku = pde[2];
            if ((wr && !okw) || (usr && !oku)) begin flt = 1; code = {usr, wr, 1'b1}; end
            else phys = {pde[31:22], lin[21:0]};
            return;
        end
        a1 = {pde[31:12], lin[21:12], 2'b00};
        pte = memrd(a1);
        nrd = 2;
        if (!pte[0]) begin
            flt = 1; code = {usr, wr, 1'b0};
            return;
        end
        okw = pde[1] && pte[1]; oku = pde[2] && pte[2];
        if ((wr && !okw) || (usr && !oku)) begin flt = 1; code = {usr, wr, 1'b1}; end
        else phys = {pte[31:12], lin[11:0]};
    endtask

    task automatic chk_eq(input string req, input logic [31:0] act, exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_walk(input string req, input logic [31:0] lin,
                           input logic wr, usr, pg, pse, input logic [19:0] base,
                           input int hold, input bit flip);
        logic [31:0] e_phys, e_a0, e_a1, s_phys;
        logic        e_flt;
        logic [2:0]  e_code;
        int          e_nrd;
        ref_walk(lin, wr, usr, pg, pse, base, e_phys, e_flt, e_code, e_nrd, e_a0, e_a1);
        @(negedge clk);
        rd_q.delete();
        chk_eq({req, " R10 idle ready"}, 32'(req_ready), 32'd1);
        req_valid = 1; req_lin = lin; req_write = wr; req_user = usr;
        pg_en = pg; pse_en = pse; dir_frame = base;
        @(negedge clk);
        req_valid = 0;
        if (flip) begin
            pg_en = !pg; pse_en = !pse; dir_frame = ~base;  // R12 late changes
        end
        while (!rsp_valid) begin
            chk_eq({req, " R10 busy not ready"}, 32'(req_ready), 32'd0);
            if (!pg) chk_eq({req, " R1 no read"}, 32'(mem_req_valid), 32'd0);
            @(negedge clk);
        end
        chk_eq({req, " phys"}, rsp_phys, e_phys);
        chk_eq({req, " fault"}, 32'(rsp_fault), 32'(e_flt));
        chk_eq({req, " code"}, 32'(rsp_fault_code), 32'(e_code));
        chk_eq({req, " read count"}, 32'(rd_q.size()), 32'(e_nrd));
        if (e_nrd >= 1 && rd_q.size() >= 1) chk_eq({req, " R2 dir addr"}, rd_q[0], e_a0);
        if (e_nrd == 2 && rd_q.size() >= 2) chk_eq({req, " R3 table addr"}, rd_q[1], e_a1);
        s_phys = rsp_phys;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            chk_eq({req, " R10 held valid"}, 32'(rsp_valid), 32'd1);
            chk_eq({req, " R10 held phys"}, rsp_phys, s_phys);
            chk_eq({req, " R10 held ready low"}, 32'(req_ready), 32'd0);
        end
        rsp_ready = 1;
        @(negedge clk);
        rsp_ready = 0;
        chk_eq({req, " R10 released"}, 32'(rsp_valid), 32'd0);
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        // directory at frame 0x00010
        mem_a[32'h0001_0004] = 32'h0002_0007;  // table, full rights
        mem_a[32'h0002_000C] = 32'h0ABC_D007;
        mem_a[32'h0002_0010] = 32'h0BEE_F005;  // read-only, user
        mem_a[32'h0002_0018] = 32'h0C00_1003;  // writable, supervisor only
        mem_a[32'h0001_0008] = 32'h2C00_0087;  // 4 MB, full rights
        mem_a[32'h2C00_0244] = 32'h5555_5007;  // used when large pages off
        mem_a[32'h0001_000C] = 32'h0003_0005;  // directory read-only
        mem_a[32'h0003_0000] = 32'h0D00_D007;
        mem_a[32'h0001_0010] = 32'h0004_0003;  // directory supervisor only
        mem_a[32'h0004_0000] = 32'h0E00_E007;
        mem_a[32'h0001_0014] = 32'h4000_0081;  // 4 MB, no rights
        mem_a[32'h0005_0004] = 32'h0002_0007;  // second directory at 0x00050

        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk_eq("R10 reset ready", 32'(req_ready), 32'd1);
        chk_eq("R10 reset no result", 32'(rsp_valid), 32'd0);
        chk_eq("R11 reset no read", 32'(mem_req_valid), 32'd0);

        do_walk("R1 paging off",         32'h1234_5678, 1, 1, 0, 1, 20'h00010, 0, 0);
        do_walk("R1 paging off held",    32'hFFFF_F001, 0, 0, 0, 0, 20'h00010, 2, 0);
        do_walk("R3 4KB map",            32'h0040_3ABC, 0, 0, 1, 1, 20'h00010, 0, 0);
        do_walk("R2 other directory",    32'h0040_3ABC, 1, 1, 1, 0, 20'h00050, 1, 0);
        do_walk("R4 4MB map",            32'h0089_1234, 1, 1, 1, 1, 20'h00010, 0, 0);
        do_walk("R5 size flag ignored",  32'h0089_1234, 0, 0, 1, 0, 20'h00010, 0, 0);
        do_walk("R6 dir not present",    32'h0000_0123, 1, 0, 1, 1, 20'h00010, 0, 0);
        do_walk("R6 table not present",  32'h0040_5000, 0, 1, 1, 1, 20'h00010, 0, 0);
        do_walk("R7 table read-only",    32'h0040_4010, 1, 0, 1, 1, 20'h00010, 0, 0);
        do_walk("R8 sup read ok",        32'h0040_4010, 0, 0, 1, 1, 20'h00010, 0, 0);
        do_walk("R7 dir read-only",      32'h00C0_0444, 1, 0, 1, 1, 20'h00010, 0, 0);
        do_walk("R8 user read dir ok",   32'h00C0_0444, 0, 1, 1, 1, 20'h00010, 0, 0);
        do_walk("R8 table sup only",     32'h0040_6008, 0, 1, 1, 1, 20'h00010, 0, 0);
        do_walk("R8 dir sup only",       32'h0100_0777, 0, 1, 1, 1, 20'h00010, 0, 0);
        do_walk("R9 4MB user write",     32'h0140_0010, 1, 1, 1, 1, 20'h00010, 0, 0);
        do_walk("R9 table user write",   32'h0040_4010, 1, 1, 1, 1, 20'h00010, 0, 0);
        do_walk("R8 4MB sup read",       32'h0140_0010, 0, 0, 1, 1, 20'h00010, 0, 0);
        do_walk("R6 np over rights",     32'h0100_1000, 0, 1, 1, 1, 20'h00010, 0, 0);
        do_walk("R12 late ctrl change",  32'h0040_3ABC, 0, 0, 1, 0, 20'h00050, 0, 1);
        do_walk("R12 late pg change",    32'h0089_1234, 0, 0, 1, 1, 20'h00010, 1, 1);
        do_walk("R11 back-to-back",      32'h0040_3FFC, 0, 0, 1, 1, 20'h00010, 0, 0);
        finish_run();
    end
endmodule